// File: doc/BRIEF.md
# Global Exclusive Access Monitor

This block stands in front of a multi-port shared memory and gives it semaphore semantics for load-exclusive and store-exclusive sequences. A request carries an exclusive flag next to its address. An exclusive read reserves an entry in a shared table. The entry records the master ID and the address granule. A later exclusive write from that master to that granule reaches memory only while the entry is still reserved. The result comes back as an exclusive-okay or plain-okay response code, and the memory write enable for that request is gated to match.

The table is common to all ports, so masters attached to different ports can lock against each other. A fixed pool of entries tracks several exclusive sequences at the same time. Plain writes clear reservations on the granule they hit. A successful exclusive write does the same, so the first of two competing stores wins. A master can also drop its own reservation with a clear request. When several ports issue requests in one cycle, they are applied in port-index order, lowest first. Each response and write enable appears one clock after its request.

Top module: `excl_monitor`

## Requirements
- R1: After reset, no response is valid and no entry is reserved, so an exclusive write returns code 2'b00 (OKAY) with the write enable low.
- R2: An exclusive read returns code 2'b01 (EXOKAY). A plain read returns 2'b00. Neither read raises the write enable.
- R3: An exclusive write whose master ID holds a reservation on the same granule returns 2'b01 and raises the write enable.
- R4: An exclusive write with no matching reservation returns 2'b00 and keeps the write enable low.
- R5: A plain write from any port returns 2'b00, raises the write enable, and removes every reservation on its granule, including reservations held by masters on other ports.
- R6: A successful exclusive write removes the reservations of all other masters on its granule.
- R7: A clear request (op 2'b10) removes only the issuing master's reservation. It returns 2'b00 with the write enable low.
- R8: A new exclusive read by a master that already holds a reservation replaces that reservation's address.
- R9: Addresses are matched per 8-byte granule, and the low 3 bits are ignored.
- R10: The pool holds 8 entries. A ninth master's exclusive read takes over the entry that was reserved least recently.
- R11: Requests presented in the same cycle are applied in ascending port order, and each one sees the table changes made by lower-numbered ports.
- R12: Each request gives exactly one response, one clock after it is presented. No response is valid in a cycle without a request. Op codes: 2'b00 read, 2'b01 write, 2'b10 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_vld_i | input | NP | Request valid, one bit per port |
| req_op_i | input | 2*NP | Op per port: 00 read, 01 write, 10 clear |
| req_excl_i | input | NP | Exclusive flag per port |
| req_id_i | input | ID_W*NP | Master ID per port |
| req_addr_i | input | AW*NP | Byte address per port |
| rsp_vld_o | output | NP | Response valid per port |
| rsp_code_o | output | 2*NP | Response code per port: 00 OKAY, 01 EXOKAY |
| mem_we_o | output | NP | Write enable toward memory per port |

## Verification
The hardest situation to reach is two ports acting on the same granule in the same clock. In that case the outcome depends on the serial order within the cycle, not on the order between cycles. The stimulus first arms two masters on one granule and then has both store in the same cycle, checking that only port 0 wins. It then pairs an exclusive read with a plain write in both port orders, so that the reservation dies in one order and survives in the other. Eviction needs the whole pool filled by eight distinct masters before a ninth one arrives.

// File: rtl/exmon_pkg.sv
package exmon_pkg;
  localparam logic [1:0] OP_RD  = 2'b00;
  localparam logic [1:0] OP_WR  = 2'b01;
  localparam logic [1:0] OP_CLR = 2'b10;
  localparam logic [1:0] RSP_OKAY   = 2'b00;
  localparam logic [1:0] RSP_EXOKAY = 2'b01;
endpackage

// File: rtl/exmon_victim.sv
module exmon_victim #(
  parameter int NE = 8,
  parameter int RW = 3
) (
  input  logic          vld_i  [NE],
  input  logic [RW-1:0] rank_i [NE],
  output logic [RW-1:0] idx_o
);
  logic found;
  always_comb begin
    found = 1'b0;
    idx_o = '0;
    for (int j = 0; j < NE; j++) begin
      if (!vld_i[j] && !found) begin
        idx_o = RW'(j);
        found = 1'b1;
      end
    end
    // all busy: oldest reservation carries the highest rank
    if (!found) begin
      for (int j = 0; j < NE; j++) begin
        if (rank_i[j] == RW'(NE-1)) idx_o = RW'(j);
      end
    end
  end
endmodule

// File: rtl/exmon_stage.sv
module exmon_stage
  import exmon_pkg::*;
#(
  parameter int NE   = 8,
  parameter int ID_W = 4,
  parameter int GA_W = 29,
  parameter int RW   = 3
) (
  input  logic            vld_i,
  input  logic [1:0]      op_i,
  input  logic            excl_i,
  input  logic [ID_W-1:0] id_i,
  input  logic [GA_W-1:0] ga_i,
  input  logic            t_vld_i  [NE],
  input  logic [ID_W-1:0] t_id_i   [NE],
  input  logic [GA_W-1:0] t_ga_i   [NE],
  input  logic [RW-1:0]   t_rank_i [NE],
  output logic            t_vld_o  [NE],
  output logic [ID_W-1:0] t_id_o   [NE],
  output logic [GA_W-1:0] t_ga_o   [NE],
  output logic [RW-1:0]   t_rank_o [NE],
  output logic            rsp_vld_o,
  output logic [1:0]      rsp_code_o,
  output logic            we_o
);
  logic [RW-1:0] vic_idx, own_idx, slot;
  logic          own_hit, hit;

  exmon_victim #(.NE(NE), .RW(RW)) u_victim (
    .vld_i (t_vld_i),
    .rank_i(t_rank_i),
    .idx_o (vic_idx)
  );

  always_comb begin
    own_hit = 1'b0;
    own_idx = '0;
    hit     = 1'b0;
    for (int j = 0; j < NE; j++) begin
      if (t_vld_i[j] && t_id_i[j] == id_i) begin
        if (!own_hit) own_idx = RW'(j);
        own_hit = 1'b1;
        if (t_ga_i[j] == ga_i) hit = 1'b1;
      end
    end
    slot = own_hit ? own_idx : vic_idx;
  end

  always_comb begin
    for (int j = 0; j < NE; j++) begin
      t_vld_o[j]  = t_vld_i[j];
      t_id_o[j]   = t_id_i[j];
      t_ga_o[j]   = t_ga_i[j];
      t_rank_o[j] = t_rank_i[j];
    end
    rsp_vld_o  = vld_i;
    rsp_code_o = RSP_OKAY;
    we_o       = 1'b0;
    if (vld_i) begin
      case (op_i)
        OP_RD: if (excl_i) begin
          for (int j = 0; j < NE; j++)
            if (t_rank_i[j] < t_rank_i[slot]) t_rank_o[j] = t_rank_i[j] + 1'b1;
          t_rank_o[slot] = '0;
          t_vld_o[slot]  = 1'b1;
          t_id_o[slot]   = id_i;
          t_ga_o[slot]   = ga_i;
          rsp_code_o     = RSP_EXOKAY;
        end
        OP_WR: if (!excl_i || hit) begin
          we_o = 1'b1;
          if (excl_i) rsp_code_o = RSP_EXOKAY;
          for (int j = 0; j < NE; j++)
            if (t_ga_i[j] == ga_i) t_vld_o[j] = 1'b0;
        end
        OP_CLR: begin
          for (int j = 0; j < NE; j++)
            if (t_id_i[j] == id_i) t_vld_o[j] = 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import exmon_pkg::*;
#(
  parameter int NP   = 2,
  parameter int NE   = 8,
  parameter int ID_W = 4,
  parameter int AW   = 32,
  parameter int GRAN = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NP-1:0]    req_vld_i,
  input  logic [2*NP-1:0]  req_op_i,
  input  logic [NP-1:0]    req_excl_i,
  input  logic [ID_W*NP-1:0] req_id_i,
  input  logic [AW*NP-1:0] req_addr_i,
  output logic [NP-1:0]    rsp_vld_o,
  output logic [2*NP-1:0]  rsp_code_o,
  output logic [NP-1:0]    mem_we_o
);
  localparam int GA_W = AW - GRAN;
  localparam int RW   = (NE > 1) ? $clog2(NE) : 1;

  logic            q_vld  [NE];
  logic [ID_W-1:0] q_id   [NE];
  logic [GA_W-1:0] q_ga   [NE];
  logic [RW-1:0]   q_rank [NE];

  logic            c_vld  [NP+1][NE];
  logic [ID_W-1:0] c_id   [NP+1][NE];
  logic [GA_W-1:0] c_ga   [NP+1][NE];
  logic [RW-1:0]   c_rank [NP+1][NE];

  logic [NP-1:0]   s_vld, s_we;
  logic [2*NP-1:0] s_code;

  always_comb begin
    for (int j = 0; j < NE; j++) begin
      c_vld[0][j]  = q_vld[j];
      c_id[0][j]   = q_id[j];
      c_ga[0][j]   = q_ga[j];
      c_rank[0][j] = q_rank[j];
    end
  end

  // ports applied serially, lowest index first
  for (genvar p = 0; p < NP; p++) begin : g_port
    exmon_stage #(.NE(NE), .ID_W(ID_W), .GA_W(GA_W), .RW(RW)) u_stage (
      .vld_i     (req_vld_i[p]),
      .op_i      (req_op_i[2*p +: 2]),
      .excl_i    (req_excl_i[p]),
      .id_i      (req_id_i[ID_W*p +: ID_W]),
      .ga_i      (req_addr_i[AW*p+GRAN +: GA_W]),
      .t_vld_i   (c_vld[p]),
      .t_id_i    (c_id[p]),
      .t_ga_i    (c_ga[p]),
      .t_rank_i  (c_rank[p]),
      .t_vld_o   (c_vld[p+1]),
      .t_id_o    (c_id[p+1]),
      .t_ga_o    (c_ga[p+1]),
      .t_rank_o  (c_rank[p+1]),
      .rsp_vld_o (s_vld[p]),
      .rsp_code_o(s_code[2*p +: 2]),
      .we_o      (s_we[p])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < NE; j++) begin
        q_vld[j]  <= 1'b0;
        q_id[j]   <= '0;
        q_ga[j]   <= '0;
        q_rank[j] <= RW'(j);
      end
      rsp_vld_o  <= '0;
      rsp_code_o <= '0;
      mem_we_o   <= '0;
    end else begin
      for (int j = 0; j < NE; j++) begin
        q_vld[j]  <= c_vld[NP][j];
        q_id[j]   <= c_id[NP][j];
        q_ga[j]   <= c_ga[NP][j];
        q_rank[j] <= c_rank[NP][j];
      end
      rsp_vld_o  <= s_vld;
      rsp_code_o <= s_code;
      mem_we_o   <= s_we;
    end
  end
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int NP = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NP-1:0]   req_vld_i,
  input logic [2*NP-1:0] req_op_i,
  input logic [NP-1:0]   req_excl_i,
  input logic [NP-1:0]   rsp_vld_o,
  input logic [2*NP-1:0] rsp_code_o,
  input logic [NP-1:0]   mem_we_o
);
  for (genvar p = 0; p < NP; p++) begin : g_chk
    // R12
    rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_vld_o[p] == $past(req_vld_i[p]));
    // R12
    we_needs_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_we_o[p] |-> rsp_vld_o[p]);
    // R2
    read_no_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_vld_i[p] && req_op_i[2*p +: 2] == 2'b00) |=> !mem_we_o[p]);
    // R5
    plain_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_vld_i[p] && req_op_i[2*p +: 2] == 2'b01 && !req_excl_i[p])
      |=> (mem_we_o[p] && rsp_code_o[2*p +: 2] == 2'b00));
    // R3
    exwr_ok_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_vld_i[p] && req_op_i[2*p +: 2] == 2'b01 && req_excl_i[p])
      |=> (mem_we_o[p] == (rsp_code_o[2*p +: 2] == 2'b01)));
    // R7
    clear_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_vld_i[p] && req_op_i[2*p +: 2] == 2'b10)
      |=> (!mem_we_o[p] && rsp_code_o[2*p +: 2] == 2'b00));
  end
endmodule

bind excl_monitor excl_monitor_chk #(.NP(NP)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_vld_i (req_vld_i),
  .req_op_i  (req_op_i),
  .req_excl_i(req_excl_i),
  .rsp_vld_o (rsp_vld_o),
  .rsp_code_o(rsp_code_o),
  .mem_we_o  (mem_we_o)
);

// File: tb/excl_monitor_test.sv
module excl_monitor_test;
  localparam int NP = 2, ID_W = 4, AW = 32;
  localparam logic [1:0] RD = 2'b00, WR = 2'b01, CLR = 2'b10;
  localparam logic [1:0] OK = 2'b00, EX = 2'b01;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] req_vld = '0, req_excl = '0;
  logic [2*NP-1:0] req_op = '0;
  logic [ID_W*NP-1:0] req_id = '0;
  logic [AW*NP-1:0] req_addr = '0;
  logic [NP-1:0] rsp_vld, mem_we;
  logic [2*NP-1:0] rsp_code;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  excl_monitor #(.NP(NP), .ID_W(ID_W), .AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_vld_i(req_vld), .req_op_i(req_op),
    .req_excl_i(req_excl), .req_id_i(req_id), .req_addr_i(req_addr),
    .rsp_vld_o(rsp_vld), .rsp_code_o(rsp_code), .mem_we_o(mem_we));

  task automatic do_reset();
    rst_n = 1'b0; req_vld = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic put(int p, logic [1:0] op, logic ex, int id, logic [AW-1:0] a);
    req_vld[p] = 1'b1; req_op[2*p +: 2] = op; req_excl[p] = ex;
    req_id[ID_W*p +: ID_W] = ID_W'(id); req_addr[AW*p +: AW] = a;
  endtask

  // one clock: request sampled at posedge, response seen at next negedge
  task automatic step();
    @(negedge clk);
    req_vld = '0;
  endtask

  task automatic chk(string rq, int p, logic v, logic [1:0] c, logic w);
    n_chk++;
    if (rsp_vld[p] !== v || rsp_code[2*p +: 2] !== c || mem_we[p] !== w) begin
      n_bad++;
      $display("FAIL %s port%0d: got vld=%b code=%b we=%b exp vld=%b code=%b we=%b",
               rq, p, rsp_vld[p], rsp_code[2*p +: 2], mem_we[p], v, c, w);
    end
  endtask

  task automatic op1(string rq, int p, logic [1:0] op, logic ex, int id,
                     logic [AW-1:0] a, logic [1:0] c, logic w);
    put(p, op, ex, id, a); step(); chk(rq, p, 1'b1, c, w);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", 0, 1'b0, OK, 1'b0); chk("R1", 1, 1'b0, OK, 1'b0);
    op1("R1", 0, WR, 1, 1, 32'h40, OK, 1'b0);
    @(negedge clk);
    chk("R12", 0, 1'b0, OK, 1'b0);
  endtask

  task automatic t_basic();
    do_reset();
    op1("R2", 0, RD, 0, 1, 32'h100, OK, 1'b0);
    op1("R2", 0, RD, 1, 1, 32'h100, EX, 1'b0);
    op1("R3", 0, WR, 1, 1, 32'h100, EX, 1'b1);
    op1("R4", 0, WR, 1, 1, 32'h100, OK, 1'b0);
    op1("R4", 1, WR, 1, 2, 32'h200, OK, 1'b0);
  endtask

  task automatic t_plain_clear();
    do_reset();
    op1("R5", 0, RD, 1, 1, 32'h300, EX, 1'b0);
    op1("R5", 1, WR, 0, 7, 32'h304, OK, 1'b1);
    op1("R5", 0, WR, 1, 1, 32'h300, OK, 1'b0);
    op1("R6", 0, RD, 1, 1, 32'h300, EX, 1'b0);
    op1("R6", 1, RD, 1, 2, 32'h300, EX, 1'b0);
    op1("R6", 1, WR, 1, 2, 32'h300, EX, 1'b1);
    op1("R6", 0, WR, 1, 1, 32'h300, OK, 1'b0);
  endtask

  task automatic t_clear();
    do_reset();
    op1("R7", 0, RD, 1, 1, 32'h500, EX, 1'b0);
    op1("R7", 1, CLR, 0, 1, 32'h0, OK, 1'b0);
    op1("R7", 0, WR, 1, 1, 32'h500, OK, 1'b0);
    op1("R7", 0, RD, 1, 1, 32'h500, EX, 1'b0);
    op1("R7", 1, CLR, 0, 2, 32'h0, OK, 1'b0);
    op1("R7", 0, WR, 1, 1, 32'h500, EX, 1'b1);
  endtask

  task automatic t_replace_gran();
    do_reset();
    op1("R8", 0, RD, 1, 3, 32'h600, EX, 1'b0);
    op1("R8", 0, RD, 1, 3, 32'h700, EX, 1'b0);
    op1("R8", 0, WR, 1, 3, 32'h600, OK, 1'b0);
    op1("R8", 0, WR, 1, 3, 32'h700, EX, 1'b1);
    op1("R9", 1, RD, 1, 4, 32'h800, EX, 1'b0);
    op1("R9", 1, WR, 1, 4, 32'h807, EX, 1'b1);
    op1("R9", 1, RD, 1, 4, 32'h800, EX, 1'b0);
    op1("R9", 1, WR, 1, 4, 32'h808, OK, 1'b0);
  endtask

  task automatic t_evict();
    do_reset();
    for (int k = 1; k <= 8; k++)
      op1("R10", k % 2, RD, 1, k, 32'h1000 + 32'(k*16), EX, 1'b0);
    op1("R10", 0, RD, 1, 9, 32'h2000, EX, 1'b0);
    op1("R10", 1, WR, 1, 1, 32'h1010, OK, 1'b0);
    op1("R10", 0, WR, 1, 2, 32'h1020, EX, 1'b1);
    op1("R10", 1, WR, 1, 9, 32'h2000, EX, 1'b1);
  endtask

  task automatic t_same_cycle();
    do_reset();
    put(0, RD, 1, 1, 32'h900); put(1, RD, 1, 2, 32'h900); step();
    chk("R11", 0, 1'b1, EX, 1'b0); chk("R11", 1, 1'b1, EX, 1'b0);
    put(0, WR, 1, 1, 32'h900); put(1, WR, 1, 2, 32'h900); step();
    chk("R11", 0, 1'b1, EX, 1'b1); chk("R11", 1, 1'b1, OK, 1'b0);
    put(0, RD, 1, 3, 32'hA00); put(1, WR, 0, 4, 32'hA00); step();
    chk("R11", 0, 1'b1, EX, 1'b0); chk("R11", 1, 1'b1, OK, 1'b1);
    op1("R11", 0, WR, 1, 3, 32'hA00, OK, 1'b0);
    put(0, WR, 0, 6, 32'hB00); put(1, RD, 1, 5, 32'hB00); step();
    chk("R11", 0, 1'b1, OK, 1'b1); chk("R11", 1, 1'b1, EX, 1'b0);
    op1("R11", 1, WR, 1, 5, 32'hB00, EX, 1'b1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_plain_clear();
    t_clear();
    t_replace_gran();
    t_evict();
    t_same_cycle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R12: got no finish, exp finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule